// File: doc/BRIEF.md
# Buffered Dual-Register PWM Timer

This block holds a free-running modulo counter and two compare channels that produce pulse-width modulated outputs. Every period starts with the output high. The output goes low when the counter reaches the pulse width held in a compare register. A compare pulse marks the falling edge of each pulse, and an overflow pulse marks the start of each period. Each event sets a sticky flag that software clears, and a set flag whose enable bit is on drives the interrupt request.

With the link bit clear, the two channels are independent, and each drives its own pin. A compare value written in this mode takes effect at once. With the link bit set, the two compare registers share the pin of channel 0. At each overflow, whichever of the two registers software wrote last becomes the active pulse width. Software can therefore prepare the next width in the idle register and have it take effect cleanly at a period boundary. Channel 1's control register is ignored in this mode, and its pin is handed back for general-purpose use.

All configuration goes through a single-cycle write port. Address map: 0 modulo, 1 compare 0, 2 compare 1, 3 channel 0 control, 4 channel 1 control, 5 timer control, 6 flag clear.

Top module: `pwm_pair_timer`

## Requirements
- R1: The counter runs from 0 up to the modulo value and wraps to 0 on the next clock, so a period lasts modulo+1 cycles. A single-cycle `ovf_pulse` marks the first cycle of each period. If the count is at or above a newly written modulo, the counter wraps on the next clock.
- R2: When the link bit is clear, each channel drives its own pin. Channel bit 0 of its control register (address 3 or 4) enables it. The pin is high for the first C cycles of each period, where C is that channel's compare value.
- R3: A pin is set at the start of a period and cleared on a compare match. The `cmp_pulse` bit of the channel is high for one cycle, in the first cycle in which the pin is low.
- R4: A compare value of 0 holds the pin low for the whole period, because the clear wins over the set. A compare value above the modulo value holds the pin high.
- R5: In unbuffered mode, a compare write takes effect on the next clock. A channel matches at most once per period, so raising the value after the match gives no second compare pulse in that period.
- R6: There are three flags: overflow, compare 0 and compare 1. Each stays set until a 1 is written to its bit at address 6 (bit 0 overflow, bit 1 compare 0, bit 2 compare 1). A set in the same cycle as a clear wins. `irq` is high while any flag is set together with its enable: timer control bit 0 for overflow, control bit 1 of each channel for its compare.
- R7: Setting the link bit (address 3, bit 2) from 0 makes compare 0 the active pulse-width source, even if compare 1 was written last.
- R8: In link mode, a write to the compare register that is not active leaves the current period unchanged. The new value takes effect from the next period.
- R9: In link mode, at every overflow, the compare register written most recently becomes the active source for the new period.
- R10: While the link bit is set, channel 1's control register has no effect, `pwm_out[1]` stays low, `cmp_flag[1]` is not set, and `pin1_gpio` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | CNT_W | Write data |
| pwm_out | output | 2 | Channel pins (bit 0 also carries the linked output) |
| pin1_gpio | output | 1 | High while channel 1's pin is released |
| ovf_pulse | output | 1 | High in the first cycle of each period |
| cmp_pulse | output | 2 | Compare event per channel, one cycle |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmp_flag | output | 2 | Sticky compare flags |
| irq | output | 1 | Interrupt request |

## Verification
Whole periods are measured at the pins with compare values below, equal to 0 and above the modulo value. These separate normal duty from the two saturated cases and show where the falling edge and the compare pulse fall. A compare value raised just after its match tells the single-match rule apart from a design that would compare again. In link mode, rewrites of the idle register and of the active register, made in the middle of a period, together with back-to-back writes to both registers, tell three behaviours apart: a switch at the boundary, an immediate switch, and selection by the last write.

// File: rtl/ptm_pkg.sv
// Package: register addresses and control bit positions shared by the
// PWM pair timer and its bench. Assumes a 3-bit register address.
package ptm_pkg;
    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_MOD   = 3'd0;
    localparam logic [ADDR_W-1:0] A_CMP0  = 3'd1;
    localparam logic [ADDR_W-1:0] A_CMP1  = 3'd2;
    localparam logic [ADDR_W-1:0] A_CTL0  = 3'd3;
    localparam logic [ADDR_W-1:0] A_CTL1  = 3'd4;
    localparam logic [ADDR_W-1:0] A_TCTL  = 3'd5;
    localparam logic [ADDR_W-1:0] A_FCLR  = 3'd6;
    localparam int B_EN   = 0;   // channel enable
    localparam int B_IE   = 1;   // compare interrupt enable
    localparam int B_LINK = 2;   // link bit, channel 0 control only
    localparam int NFLAG  = 3;   // overflow, compare 0, compare 1
    typedef struct packed {
        logic en;
        logic ie;
    } ch_ctl_t;
endpackage

// File: rtl/ptm_counter.sv
// Modulo counter: counts 0..mod_val and wraps to 0 on the next clock.
// Assumes mod_val may change at any time; a count at or above it wraps.
module ptm_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] mod_val,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] cnt_nxt_o,
    output logic         wrap_o
);
    logic [W-1:0] cnt_q;

    assign wrap_o    = (cnt_q >= mod_val);
    assign cnt_nxt_o = wrap_o ? '0 : cnt_q + 1'b1;
    assign cnt_o     = cnt_q;

    // Advance the count every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_nxt_o;
    end

    p_wrap_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (cnt_q == '0));
    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_o |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/ptm_engine.sv
// One PWM compare engine: sets its pin at period start and clears it when
// the next count equals the compare value, at most once per period.
// Assumes wrap/cnt_nxt come from the shared counter; clear beats set.
module ptm_engine #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         wrap,
    input  logic [W-1:0] cnt_nxt,
    input  logic [W-1:0] cmp_val,
    output logic         pin_o,
    output logic         match_o
);
    logic pin_q, done_q, match_q;
    logic done_eff, match;

    assign done_eff = wrap ? 1'b0 : done_q;
    assign match    = en && !done_eff && (cnt_nxt == cmp_val);
    assign pin_o    = pin_q;
    assign match_o  = match_q;

    // Drive the pin: clear on match, set at period start, low when off.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) pin_q <= 1'b0;
        else if (match)    pin_q <= 1'b0;
        else if (wrap)     pin_q <= 1'b1;
    end

    // Remember that this period has already matched.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= done_eff | match;
    end

    // Register the compare event so it lines up with the falling pin.
    always_ff @(posedge clk) begin
        if (!rst_n) match_q <= 1'b0;
        else        match_q <= match;
    end

    p_fall_on_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> !pin_q);
    p_rise_at_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && wrap && !match) |=> pin_q);
    p_once_per_period_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (match && !wrap) |=> !match_q || !$past(done_q));
endmodule

// File: rtl/ptm_link_sel.sv
// Link steering: tracks which compare register was written last and, in
// link mode, hands that register to engine 0 at each counter wrap.
// Assumes single-port writes, so both compares never write together.
module ptm_link_sel #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         link,
    input  logic         link_rise,
    input  logic         wr_cmp0,
    input  logic         wr_cmp1,
    input  logic         wrap,
    input  logic [W-1:0] cmp0,
    input  logic [W-1:0] cmp1,
    output logic [W-1:0] cmp_ch0
);
    logic sel_q, last_q, sel_eff;

    assign sel_eff = wrap ? last_q : sel_q;
    assign cmp_ch0 = (link && sel_eff) ? cmp1 : cmp0;

    // Record the register written most recently; link entry favours 0.
    always_ff @(posedge clk) begin
        if (!rst_n || link_rise) last_q <= 1'b0;
        else if (wr_cmp1)        last_q <= 1'b1;
        else if (wr_cmp0)        last_q <= 1'b0;
    end

    // Change the active source only at a wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || link_rise) sel_q <= 1'b0;
        else if (wrap)           sel_q <= last_q;
    end

    p_sel_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (link && !wrap) |=> $stable(sel_q));
    p_entry_ch0_r7: assert property (@(posedge clk) disable iff (!rst_n)
        link_rise |=> (!sel_q && !last_q));
    p_wrap_takes_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !link_rise) |=> (sel_q == $past(last_q)));
endmodule

// File: rtl/ptm_flags.sv
// Sticky event flags with write-1-to-clear and per-flag enables; the
// request is the OR of enabled flags. A set wins over a clear.
module ptm_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic [N-1:0] ie_i,
    output logic [N-1:0] flag_o,
    output logic         irq_o
);
    logic [N-1:0] flag_q;

    assign flag_o = flag_q;
    assign irq_o  = |(flag_q & ie_i);

    for (genvar i = 0; i < N; i++) begin : g_flag
        // Hold the flag until software clears it.
        always_ff @(posedge clk) begin
            if (!rst_n)        flag_q[i] <= 1'b0;
            else if (set_i[i]) flag_q[i] <= 1'b1;
            else if (clr_i[i]) flag_q[i] <= 1'b0;
        end

        p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[i] && !clr_i[i]) |=> flag_q[i]);
        p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> flag_q[i]);
    end
endmodule

// File: rtl/pwm_pair_timer.sv
// Top: register file, shared modulo counter, link steering, two compare
// engines and the flag block. Assumes writes are single-cycle strobes.
module pwm_pair_timer
    import ptm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [1:0]        pwm_out,
    output logic              pin1_gpio,
    output logic              ovf_pulse,
    output logic [1:0]        cmp_pulse,
    output logic              ovf_flag,
    output logic [1:0]        cmp_flag,
    output logic              irq
);
    localparam int NCH = 2;

    logic [CNT_W-1:0] mod_q;
    logic [CNT_W-1:0] cmp_q [NCH];
    ch_ctl_t          ctl_q [NCH];
    logic             link_q, ovf_ie_q, ovf_q;
    logic             wr_mod, wr_ctl0, wr_ctl1, wr_tctl, wr_fclr, link_rise;
    logic [NCH-1:0]   wr_cmp, eng_en, eng_pin, eng_match;
    logic [CNT_W-1:0] cnt, cnt_nxt, cmp_ch0;
    logic [CNT_W-1:0] eng_cmp [NCH];
    logic             wrap;
    logic [NFLAG-1:0] fset, fclr, fie, fval;

    assign wr_mod    = wr_en && (wr_addr == A_MOD);
    assign wr_cmp[0] = wr_en && (wr_addr == A_CMP0);
    assign wr_cmp[1] = wr_en && (wr_addr == A_CMP1);
    assign wr_ctl0   = wr_en && (wr_addr == A_CTL0);
    assign wr_ctl1   = wr_en && (wr_addr == A_CTL1);
    assign wr_tctl   = wr_en && (wr_addr == A_TCTL);
    assign wr_fclr   = wr_en && (wr_addr == A_FCLR);
    assign link_rise = wr_ctl0 && wr_data[B_LINK] && !link_q;

    // Modulo and timer control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mod_q    <= '1;
            ovf_ie_q <= 1'b0;
        end else begin
            if (wr_mod)  mod_q    <= wr_data;
            if (wr_tctl) ovf_ie_q <= wr_data[0];
        end
    end

    // Channel 0 control, including the link bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q[0] <= '0;
            link_q   <= 1'b0;
        end else if (wr_ctl0) begin
            ctl_q[0] <= '{en: wr_data[B_EN], ie: wr_data[B_IE]};
            link_q   <= wr_data[B_LINK];
        end
    end

    // Channel 1 control.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctl_q[1] <= '0;
        else if (wr_ctl1) ctl_q[1] <= '{en: wr_data[B_EN], ie: wr_data[B_IE]};
    end

    // Compare registers, each updated directly on its write.
    for (genvar c = 0; c < NCH; c++) begin : g_cmp
        always_ff @(posedge clk) begin
            if (!rst_n)         cmp_q[c] <= '0;
            else if (wr_cmp[c]) cmp_q[c] <= wr_data;
        end
    end

    // Overflow event aligned with the first cycle of a period.
    always_ff @(posedge clk) begin
        if (!rst_n) ovf_q <= 1'b0;
        else        ovf_q <= wrap;
    end

    ptm_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .mod_val(mod_q),
        .cnt_o(cnt), .cnt_nxt_o(cnt_nxt), .wrap_o(wrap)
    );

    ptm_link_sel #(.W(CNT_W)) u_sel (
        .clk(clk), .rst_n(rst_n), .link(link_q), .link_rise(link_rise),
        .wr_cmp0(wr_cmp[0]), .wr_cmp1(wr_cmp[1]), .wrap(wrap),
        .cmp0(cmp_q[0]), .cmp1(cmp_q[1]), .cmp_ch0(cmp_ch0)
    );

    assign eng_cmp[0] = cmp_ch0;
    assign eng_cmp[1] = cmp_q[1];
    assign eng_en[0]  = ctl_q[0].en;
    assign eng_en[1]  = ctl_q[1].en && !link_q;

    for (genvar c = 0; c < NCH; c++) begin : g_eng
        ptm_engine #(.W(CNT_W)) u_eng (
            .clk(clk), .rst_n(rst_n), .en(eng_en[c]), .wrap(wrap),
            .cnt_nxt(cnt_nxt), .cmp_val(eng_cmp[c]),
            .pin_o(eng_pin[c]), .match_o(eng_match[c])
        );
    end

    assign fset = {eng_match[1], eng_match[0], wrap};
    assign fclr = wr_fclr ? wr_data[NFLAG-1:0] : '0;
    assign fie  = {ctl_q[1].ie && !link_q, ctl_q[0].ie, ovf_ie_q};

    ptm_flags #(.N(NFLAG)) u_flags (
        .clk(clk), .rst_n(rst_n), .set_i(fset), .clr_i(fclr),
        .ie_i(fie), .flag_o(fval), .irq_o(irq)
    );

    assign pwm_out   = eng_pin;
    assign pin1_gpio = link_q;
    assign ovf_pulse = ovf_q;
    assign cmp_pulse = eng_match;
    assign ovf_flag  = fval[0];
    assign cmp_flag  = fval[2:1];

    p_pin1_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(link_q) |-> (!pwm_out[1] && !cmp_pulse[1]));
    p_ovf_once_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> (cnt == '0));
    p_zero_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && eng_cmp[0] == '0) |=> !pwm_out[0]);
endmodule

// File: tb/sim_pwm_pair_timer.sv
module sim_pwm_pair_timer;
    import ptm_pkg::*;
    localparam int W = 16;

    logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
    logic [2:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic [1:0] pwm_out, cmp_pulse, cmp_flag;
    logic pin1_gpio, ovf_pulse, ovf_flag, irq;
    int n_run = 0, n_fail = 0, cur_mod = 9;
    bit finished = 0;

    always #4 clk = ~clk;

    pwm_pair_timer #(.CNT_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_out(pwm_out), .pin1_gpio(pin1_gpio),
        .ovf_pulse(ovf_pulse), .cmp_pulse(cmp_pulse), .ovf_flag(ovf_flag),
        .cmp_flag(cmp_flag), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // All tasks start and end just after a falling clock edge.
    task automatic wr(input logic [2:0] a, input int d);
        wr_en = 1'b1; wr_addr = a; wr_data = W'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic sync_ovf();
        while (!ovf_pulse) @(negedge clk);
    endtask

    // Measure one whole period on channel ch, optionally writing at index wr_at.
    task automatic measure(input int ch, input int wr_at, input logic [2:0] a,
                           input int d, output int hi, output int ncmp,
                           output int novf, output int first_low, output int cmp_at);
        hi = 0; ncmp = 0; novf = 0; first_low = -1; cmp_at = -1;
        sync_ovf();
        for (int i = 0; i <= cur_mod; i++) begin
            if (pwm_out[ch]) hi++;
            else if (first_low < 0) first_low = i;
            if (cmp_pulse[ch]) begin ncmp++; if (cmp_at < 0) cmp_at = i; end
            if (ovf_pulse) novf++;
            if (i == wr_at) begin wr_en = 1'b1; wr_addr = a; wr_data = W'(d); end
            else wr_en = 1'b0;
            @(negedge clk);
        end
        wr_en = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 reset pins", int'(pwm_out), 0);
        chk("R6 reset flags", int'({ovf_flag, cmp_flag, irq}), 0);
        chk("R10 reset gpio", int'(pin1_gpio), 0);
    endtask

    task automatic t_period();
        int len;
        wr(A_MOD, 9); cur_mod = 9;
        sync_ovf(); @(negedge clk); len = 1;
        while (!ovf_pulse) begin len++; @(negedge clk); end
        chk("R1 period mod9", len, 10);
        wr(A_MOD, 4); cur_mod = 4;
        sync_ovf(); @(negedge clk); len = 1;
        while (!ovf_pulse) begin len++; @(negedge clk); end
        chk("R1 period mod4", len, 5);
        wr(A_MOD, 9); cur_mod = 9;
    endtask

    task automatic t_unbuffered();
        int hi, nc, no, fl, ca;
        wr(A_CMP0, 3); wr(A_CMP1, 7);
        wr(A_CTL0, 1); wr(A_CTL1, 1);
        measure(0, -1, 0, 0, hi, nc, no, fl, ca);
        chk("R2 ch0 high", hi, 3);
        chk("R1 one ovf per period", no, 1);
        chk("R3 fall index", fl, 3);
        chk("R3 cmp pulse index", ca, 3);
        measure(1, -1, 0, 0, hi, nc, no, fl, ca);
        chk("R2 ch1 high", hi, 7);
        chk("R3 ch1 one cmp", nc, 1);
    endtask

    task automatic t_extremes();
        int hi, nc, no, fl, ca;
        wr(A_CMP0, 0);
        measure(0, -1, 0, 0, hi, nc, no, fl, ca);
        chk("R4 zero duty", hi, 0);
        wr(A_CMP0, 12);
        measure(0, -1, 0, 0, hi, nc, no, fl, ca);
        chk("R4 full duty", hi, 10);
        chk("R4 no cmp when above mod", nc, 0);
    endtask

    task automatic t_late_write();
        int hi, nc, no, fl, ca;
        wr(A_CMP0, 3);
        measure(0, -1, 0, 0, hi, nc, no, fl, ca);
        measure(0, 4, A_CMP0, 7, hi, nc, no, fl, ca);
        chk("R5 late write period high", hi, 3);
        chk("R5 single match", nc, 1);
        measure(0, -1, 0, 0, hi, nc, no, fl, ca);
        chk("R5 immediate new width", hi, 7);
        wr(A_CMP0, 3);
    endtask

    task automatic t_flags();
        sync_ovf();
        wr(A_FCLR, 7);
        chk("R6 cleared", int'({ovf_flag, cmp_flag}), 0);
        chk("R6 irq off", int'(irq), 0);
        repeat (3) @(negedge clk);
        chk("R6 cmp0 flag set", int'(cmp_flag[0]), 1);
        chk("R6 irq masked", int'(irq), 0);
        wr(A_CTL0, 3);
        chk("R6 irq enabled", int'(irq), 1);
        wr(A_FCLR, 2);
        chk("R6 w1c cmp0", int'(cmp_flag[0]), 0);
        chk("R6 irq dropped", int'(irq), 0);
        wr(A_TCTL, 1);
        chk("R6 ovf not yet", int'(irq), 0);
        sync_ovf();
        chk("R6 ovf flag", int'(ovf_flag), 1);
        chk("R6 ovf irq", int'(irq), 1);
        wr(A_TCTL, 0); wr(A_CTL0, 1); wr(A_FCLR, 7);
    endtask

    task automatic t_link();
        int hi, nc, no, fl, ca;
        wr(A_CMP1, 6);
        wr(A_CTL0, 5);
        measure(0, -1, 0, 0, hi, nc, no, fl, ca);
        chk("R7 entry uses cmp0", hi, 3);
        measure(0, 1, A_CMP1, 8, hi, nc, no, fl, ca);
        chk("R8 current period unchanged", hi, 3);
        measure(0, 1, A_CMP0, 2, hi, nc, no, fl, ca);
        chk("R8 cmp1 takes over next period", hi, 8);
        measure(0, -1, 0, 0, hi, nc, no, fl, ca);
        chk("R9 cmp0 written last", hi, 2);
        sync_ovf();
        wr(A_CMP1, 5); wr(A_CMP0, 4);
        measure(0, -1, 0, 0, hi, nc, no, fl, ca);
        chk("R9 last of two writes", hi, 4);
        chk("R3 linked cmp pulse", ca, 4);
        wr(A_CTL1, 3); wr(A_FCLR, 4);
        measure(1, -1, 0, 0, hi, nc, no, fl, ca);
        chk("R10 pin1 low", hi, 0);
        chk("R10 no ch1 cmp", nc, 0);
        chk("R10 cmp1 flag", int'(cmp_flag[1]), 0);
        chk("R10 gpio released", int'(pin1_gpio), 1);
        chk("R10 irq unaffected", int'(irq), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_period();
        t_unbuffered();
        t_extremes();
        t_late_write();
        t_flags();
        t_link();
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule